// File: doc/BRIEF.md
# GPIO Interrupt Detection Controller

This block is a 32-pin general-purpose I/O bank with a small memory-mapped register file. Software drives output values and output enables for each pin, reads back the synchronized pad levels, and sets up interrupt detection on the pins that are inputs. Each input pin has its own detector. It can be set to sense a low level, a high level, a rising edge or a falling edge. A per-pin any-edge override makes the detector fire on both edges instead.

Detected events latch into sticky status bits. Software clears a status bit by writing 1 to it. The status bits are gated by a mask register and drive three kinds of interrupt line:

- one combined line for the lower half of the bank;
- one combined line for the upper half;
- a dedicated line for each of the eight lowest pins, so that those pins can be routed to a distributor on their own.

The register port is a plain synchronous interface. A write takes effect at the clock edge where select and write are both high. Reads are combinational from the word address.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset, the data, direction, both configuration, mask and any-edge registers read 0, and every interrupt output is low.
- R2: The register map uses these byte addresses: 0x00 output data, 0x04 direction, 0x08 synchronized pad levels (read-only), 0x0C configuration for pins 0-15, 0x10 configuration for pins 16-31, 0x14 mask, 0x18 status, 0x1C any-edge select. Writable registers read back what was written.
- R3: The mode of pin n is held in bits [2(n mod 16)+1 : 2(n mod 16)] of its half's configuration register. The codes are 00 low level, 01 high level, 10 rising edge and 11 falling edge. For example, 0x0400 at 0x0C makes pin 5 active-high.
- R4: In a level mode, the status bit is set on every cycle that the synchronized pin is at the active level. A write-1 clear made while the level persists leaves the bit set.
- R5: In an edge mode, only the selected transition sets the status bit. The bit stays set after the pin returns to its idle level.
- R6: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. When an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: A 1 in the any-edge register makes both rising and falling transitions set that pin's status, whatever its configured mode.
- R8: A pin whose direction bit is 1 (output) never sets its status bit.
- R9: irq_lo is the OR of status AND mask over pins 0-15, and irq_hi is the same OR over pins 16-31. A status bit whose mask bit is 0 drives no interrupt line.
- R10: irq_pin[k], for k = 0..7, is high exactly when status bit k and mask bit k are both 1.
- R11: A pad change sets status three clock edges after it is applied: two synchronizer stages, then the status register.
- R12: pad_out follows the data register and pad_oe follows the direction register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe (with bus_sel) |
| bus_addr | input | 5 | Byte address of a 32-bit register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Output data to pads |
| pad_oe | output | 32 | Output enable per pad (1 = drive) |
| irq_lo | output | 1 | Combined interrupt, pins 0-15 |
| irq_hi | output | 1 | Combined interrupt, pins 16-31 |
| irq_pin | output | 8 | Dedicated interrupts, pins 0-7 |

## Verification
The bound checker checks these properties on every cycle:

- the combined and dedicated lines match masked status (R9, R10);
- a status bit never falls unless a status write happened;
- an output-direction pin never gains a status bit (R8).

Some behaviour can only be shown by the bench's sweep over every pin in all four modes and in any-edge mode. This covers which transition sets a bit and the three-edge latency. It also covers the write-1 clear losing to a concurrent level event, and edge modes staying quiet on the return transition.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int ADDR_W = 5;

  typedef enum logic [1:0] {
    DET_LOW  = 2'b00,
    DET_HIGH = 2'b01,
    DET_RISE = 2'b10,
    DET_FALL = 2'b11
  } det_mode_e;

  localparam logic [ADDR_W-1:0] OFS_DATA    = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_DIR     = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_PADS    = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_CFG_LO  = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_CFG_HI  = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_MASK    = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_STAT    = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_ANYEDGE = 5'h1C;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_d;
      if (s == 0) begin : g_first
        assign stage_d = async_i;
      end else begin : g_next
        assign stage_d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_d;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_detect.sv
module gpio_detect
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NPINS-1:0]   pin_s,
  input  logic [2*NPINS-1:0] mode_cfg,
  input  logic [NPINS-1:0]   anyedge,
  input  logic [NPINS-1:0]   dir,
  output logic [NPINS-1:0]   evt_o
);

  // Value of each synchronized pin one cycle earlier, used for edges.
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pin_s;
  end

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
      logic [1:0] code;
      logic       hit;
      logic       rise;
      logic       fall;

      assign code = mode_cfg[2*i+1:2*i];
      assign rise = pin_s[i] & ~prev_q[i];
      assign fall = ~pin_s[i] & prev_q[i];

      always_comb begin
        case (code)
          DET_LOW:  hit = ~pin_s[i];
          DET_HIGH: hit = pin_s[i];
          DET_RISE: hit = rise;
          default:  hit = fall;
        endcase
      end

      // Output pins are never qualified; any-edge outranks the mode code.
      assign evt_o[i] = ~dir[i] & (anyedge[i] ? (rise | fall) : hit);
    end
  endgenerate

endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pin_s,
  input  logic [NPINS-1:0]   evt,
  output logic [NPINS-1:0]   data_q,
  output logic [NPINS-1:0]   dir_q,
  output logic [2*NPINS-1:0] mode_cfg,
  output logic [NPINS-1:0]   mask_q,
  output logic [NPINS-1:0]   anyedge_q,
  output logic [NPINS-1:0]   status_q
);

  logic [NPINS-1:0] cfg_lo_q, cfg_hi_q;
  logic             wr_hit;
  logic             data_en, dir_en, cfg_lo_en, cfg_hi_en, mask_en, any_en, stat_wr;
  logic [NPINS-1:0] clr_bits;
  logic [NPINS-1:0] status_d;

  // Next-state logic
  always_comb begin
    wr_hit    = bus_sel & bus_wr;
    data_en   = wr_hit && (bus_addr == OFS_DATA);
    dir_en    = wr_hit && (bus_addr == OFS_DIR);
    cfg_lo_en = wr_hit && (bus_addr == OFS_CFG_LO);
    cfg_hi_en = wr_hit && (bus_addr == OFS_CFG_HI);
    mask_en   = wr_hit && (bus_addr == OFS_MASK);
    any_en    = wr_hit && (bus_addr == OFS_ANYEDGE);
    stat_wr   = wr_hit && (bus_addr == OFS_STAT);
    clr_bits  = stat_wr ? bus_wdata : '0;
    // A new event outranks a write-1 clear of the same bit.
    status_d  = (status_q & ~clr_bits) | evt;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q    <= '0;
      dir_q     <= '0;
      cfg_lo_q  <= '0;
      cfg_hi_q  <= '0;
      mask_q    <= '0;
      anyedge_q <= '0;
      status_q  <= '0;
    end else begin
      if (data_en)   data_q    <= bus_wdata;
      if (dir_en)    dir_q     <= bus_wdata;
      if (cfg_lo_en) cfg_lo_q  <= bus_wdata;
      if (cfg_hi_en) cfg_hi_q  <= bus_wdata;
      if (mask_en)   mask_q    <= bus_wdata;
      if (any_en)    anyedge_q <= bus_wdata;
      status_q <= status_d;
    end
  end

  assign mode_cfg = {cfg_hi_q, cfg_lo_q};

  // Read mux
  always_comb begin
    case (bus_addr)
      OFS_DATA:    bus_rdata = data_q;
      OFS_DIR:     bus_rdata = dir_q;
      OFS_PADS:    bus_rdata = pin_s;
      OFS_CFG_LO:  bus_rdata = cfg_lo_q;
      OFS_CFG_HI:  bus_rdata = cfg_hi_q;
      OFS_MASK:    bus_rdata = mask_q;
      OFS_STAT:    bus_rdata = status_q;
      OFS_ANYEDGE: bus_rdata = anyedge_q;
      default:     bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge #(
  parameter int NPINS   = 32,
  parameter int NDIRECT = 8
) (
  input  logic [NPINS-1:0]   status,
  input  logic [NPINS-1:0]   mask,
  output logic               irq_lo,
  output logic               irq_hi,
  output logic [NDIRECT-1:0] irq_pin
);

  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] live;

  assign live   = status & mask;
  assign irq_lo = |live[HALF-1:0];
  assign irq_hi = |live[NPINS-1:HALF];

  generate
    for (genvar k = 0; k < NDIRECT; k++) begin : g_direct
      assign irq_pin[k] = live[k];
    end
  endgenerate

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
  import gpio_irq_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int NDIRECT     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [NPINS-1:0]   bus_wdata,
  output logic [NPINS-1:0]   bus_rdata,
  input  logic [NPINS-1:0]   pad_in,
  output logic [NPINS-1:0]   pad_out,
  output logic [NPINS-1:0]   pad_oe,
  output logic               irq_lo,
  output logic               irq_hi,
  output logic [NDIRECT-1:0] irq_pin
);

  logic [NPINS-1:0]   pin_s;
  logic [NPINS-1:0]   evt;
  logic [NPINS-1:0]   data_q, dir_q, mask_q, anyedge_q, status_q;
  logic [2*NPINS-1:0] mode_cfg;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pad_in),
    .sync_o  (pin_s)
  );

  gpio_detect #(.NPINS(NPINS)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_s    (pin_s),
    .mode_cfg (mode_cfg),
    .anyedge  (anyedge_q),
    .dir      (dir_q),
    .evt_o    (evt)
  );

  gpio_regs #(.NPINS(NPINS)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_s     (pin_s),
    .evt       (evt),
    .data_q    (data_q),
    .dir_q     (dir_q),
    .mode_cfg  (mode_cfg),
    .mask_q    (mask_q),
    .anyedge_q (anyedge_q),
    .status_q  (status_q)
  );

  gpio_irq_merge #(.NPINS(NPINS), .NDIRECT(NDIRECT)) u_merge (
    .status  (status_q),
    .mask    (mask_q),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .irq_pin (irq_pin)
  );

  assign pad_out = data_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk
  import gpio_irq_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int NDIRECT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [NPINS-1:0]   status_q,
  input logic [NPINS-1:0]   mask_q,
  input logic [NPINS-1:0]   dir_q,
  input logic               irq_lo,
  input logic               irq_hi,
  input logic [NDIRECT-1:0] irq_pin
);

  localparam int HALF = NPINS / 2;

  logic stat_write;
  assign stat_write = bus_sel && bus_wr && (bus_addr == OFS_STAT);

  // R6: without a status write, no status bit can fall.
  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_write |=> ((status_q & $past(status_q)) == $past(status_q)));

  // R8: a pin set as output gains no status bit.
  p_out_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dir_q) |=> ((status_q & ~$past(status_q) & $past(dir_q)) == '0));

  // R9: lower combined line tracks masked status of pins 0-15.
  p_half_lo_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo == (|(status_q[HALF-1:0] & mask_q[HALF-1:0])));

  // R9: upper combined line tracks masked status of pins 16-31.
  p_half_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi == (|(status_q[NPINS-1:HALF] & mask_q[NPINS-1:HALF])));

  // R10: each dedicated line follows only its own pin.
  p_direct_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == (status_q[NDIRECT-1:0] & mask_q[NDIRECT-1:0]));

endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NPINS(NPINS), .NDIRECT(NDIRECT)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_sel  (bus_sel),
  .bus_wr   (bus_wr),
  .bus_addr (bus_addr),
  .status_q (status_q),
  .mask_q   (mask_q),
  .dir_q    (dir_q),
  .irq_lo   (irq_lo),
  .irq_hi   (irq_hi),
  .irq_pin  (irq_pin)
);

// File: tb/gpio_irq_bank_tb_top.sv
module gpio_irq_bank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [31:0] pad_in, pad_out, pad_oe;
  logic        irq_lo, irq_hi;
  logic [7:0]  irq_pin;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_bank dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .irq_lo(irq_lo), .irq_hi(irq_hi), .irq_pin(irq_pin)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a negedge; the write lands on the next posedge.
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] r;
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    pad_in = '0;
    settle(3);
    // R1 reset state
    chk("R1 irq", {irq_hi, irq_lo, irq_pin}, '0);
    rd(5'h14, r); chk("R1 mask", r, '0);
    rd(5'h04, r); chk("R1 dir", r, '0);
    rd(5'h0C, r); chk("R1 cfg_lo", r, '0);
    rd(5'h10, r); chk("R1 cfg_hi", r, '0);
    rd(5'h1C, r); chk("R1 anyedge", r, '0);
    chk("R1 pad_oe", pad_oe, '0);
    rst_n = 1'b1;
    settle(1);

    // R12 pad drive
    wr(5'h00, 32'hA5A5_0F0F); chk("R12 pad_out", pad_out, 32'hA5A5_0F0F);
    wr(5'h04, 32'hFFFF_0000); chk("R12 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(5'h04, r); chk("R2 dir readback", r, 32'hFFFF_0000);
    wr(5'h04, 32'h0);
    // R2/R3 map and layout
    wr(5'h0C, 32'h0000_0400); rd(5'h0C, r); chk("R3 cfg_lo readback", r, 32'h400);
    wr(5'h14, 32'h0000_005A); rd(5'h14, r); chk("R2 mask readback", r, 32'h5A);
    wr(5'h1C, 32'h0000_0003); rd(5'h1C, r); chk("R2 anyedge readback", r, 32'h3);
    wr(5'h1C, 32'h0);
    pad_in = 32'h1234_5678; settle(3);
    rd(5'h08, r); chk("R2 pad levels", r, 32'h1234_5678);
    // R3 example: pin 5 high with cfg_lo=0x400, others low-level; keep pads high except tests
    pad_in = 32'hFFFF_FFDF; wr(5'h14, 32'h0); settle(4);
    wr(5'h18, 32'hFFFF_FFFF); rd(5'h18, r); chk("R3 pin5 idle", r, 32'h0);
    pad_in[5] = 1'b1; settle(4);
    rd(5'h18, r); chk("R3 pin5 active-high", r, 32'h20);

    // R11 latency, all pins high-level
    wr(5'h0C, 32'h5555_5555); wr(5'h10, 32'h5555_5555);
    wr(5'h14, 32'hFFFF_FFFF);
    pad_in = '0; settle(4);
    wr(5'h18, 32'hFFFF_FFFF);
    pad_in[3] = 1'b1;
    settle(2); rd(5'h18, r); chk("R11 two edges", r, 32'h0);
    settle(1); rd(5'h18, r); chk("R11 three edges", r, 32'h8);
    chk("R10 pin3 line", {24'h0, irq_pin}, 32'h8);
    pad_in = '0; settle(4); wr(5'h18, 32'hFFFF_FFFF);

    // R8 output pins never flag
    wr(5'h04, 32'hFFFF_FFFF);
    pad_in = 32'hFFFF_FFFF; settle(4);
    pad_in = '0; settle(4);
    rd(5'h18, r); chk("R8 output pins quiet", r, 32'h0);
    chk("R8 irq quiet", {irq_hi, irq_lo}, '0);
    wr(5'h04, 32'h0);

    // R9 mask gating on pin 20
    wr(5'h14, 32'h0);
    pad_in[20] = 1'b1; settle(4);
    rd(5'h18, r); chk("R9 status set", r, 32'h0010_0000);
    chk("R9 masked off", {irq_hi, irq_lo}, 2'b00);
    wr(5'h14, 32'h0010_0000);
    chk("R9 masked on", {irq_hi, irq_lo}, 2'b10);
    pad_in = '0; settle(4); wr(5'h18, 32'hFFFF_FFFF);

    // Sweep: every pin, modes 0..3, then any-edge (m=4)
    for (int m = 0; m < 5; m++) begin
      for (int p = 0; p < 32; p++) begin
        logic [1:0]  code;
        logic        idle;
        logic [31:0] bit_p;
        logic [31:0] exp_clr, exp_ret;
        code  = (m == 4) ? 2'b01 : 2'(m);
        idle  = (m == 0) || (m == 3);
        bit_p = 32'(1) << p;
        exp_clr = (m < 2) ? bit_p : 32'h0;
        exp_ret = (m < 2 || m == 4) ? bit_p : 32'h0;
        pad_in = {32{idle}};
        wr(5'h0C, {16{code}});
        wr(5'h10, {16{code}});
        wr(5'h1C, (m == 4) ? 32'hFFFF_FFFF : 32'h0);
        wr(5'h14, bit_p);
        settle(4);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h18, r); chk("R6 cleared", r, 32'h0);
        chk("R9 lines idle", {22'h0, irq_hi, irq_lo, irq_pin}, 32'h0);
        pad_in[p] = ~idle; settle(4);
        // R4 level, R5 edge, R7 any-edge activation
        rd(5'h18, r); chk("R4/R5/R7 activation", r, bit_p);
        chk("R9 combined", {30'h0, irq_hi, irq_lo}, {30'h0, p >= 16, p < 16});
        chk("R10 dedicated", {24'h0, irq_pin}, (p < 8) ? bit_p : 32'h0);
        wr(5'h18, ~bit_p);
        rd(5'h18, r); chk("R6 write-0 keeps", r, bit_p);
        wr(5'h18, bit_p);
        rd(5'h18, r); chk("R6/R4 clear vs event", r, exp_clr);
        pad_in[p] = idle; settle(4);
        rd(5'h18, r); chk("R5/R7 return transition", r, exp_ret);
      end
    end

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule